// File: doc/BRIEF.md
# Flag-Conditioned Branch Target Unit

This block resolves the next 12-bit instruction address for the control-transfer instructions of a small 8-bit processor. A request carries the opcode byte, the two bytes that follow it, the value of the register the opcode names, the 4-bit flag register and the address of the next sequential instruction. The unit captures these, classifies the opcode, tests a flag where the opcode asks for it, and reports the address the processor must fetch from next together with an indication of whether control was redirected.

The work is sequenced by a three-state machine. `ST_IDLE` waits for a request; the transition idle-to-calc fires when `req_valid` is high in `ST_IDLE` and captures all operands. `ST_CALC` evaluates the captured operands and registers the result; the transition calc-to-done is unconditional. `ST_DONE` presents the result with `res_valid` high for exactly one cycle; the transition done-to-idle is unconditional. Requests seen in `ST_CALC` or `ST_DONE` are dropped. Flag updates and instruction fetch belong to other blocks.

Top module: `flow_redirect_unit`

## Requirements
- R1: After reset `res_valid`, `taken` and `next_ip` are all zero.
- R2: A request accepted in the idle state yields `res_valid` high exactly two clock edges later, for exactly one cycle.
- R3: Opcode `11000xxx` (absolute jump) gives `next_ip` = {low nibble of `imm_a`, `imm_b`} and `taken` = 1.
- R4: Opcode `11001rrr` (jump with offset) gives `next_ip` = the same 12-bit immediate plus `reg_val` zero-extended, and `taken` = 1.
- R5: Opcode `11100xxx` gives `next_ip` = `seq_ip` + `imm_a`; opcode `11101xxx` gives `seq_ip` - `imm_a`; both with `taken` = 1.
- R6: For opcodes `1111dpff`, bits ff pick the flag bit of `flags` (00 bit 0 carry, 01 bit 1 overflow, 10 bit 2 interrupt enable, 11 bit 3 user); the branch is taken when that flag equals p (p = 0 branches on clear, p = 1 on set).
- R7: A taken conditional branch moves forward (`seq_ip` + `imm_a`) when d = 0 and backward (`seq_ip` - `imm_a`) when d = 1, so a backward displacement of 2 from a two-byte branch targets the branch itself.
- R8: A conditional branch whose test fails gives `next_ip` = `seq_ip` and `taken` = 0.
- R9: Any opcode outside the five groups above gives `next_ip` = `seq_ip` and `taken` = 0.
- R10: All address arithmetic wraps modulo 4096.
- R11: A request raised while a previous one is in `ST_CALC` or `ST_DONE` is ignored; the result shown belongs to the accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled in the idle state |
| opcode | input | 8 | First instruction byte |
| imm_a | input | 8 | Second instruction byte (displacement, or high nibble of a jump target) |
| imm_b | input | 8 | Third instruction byte (low byte of a jump target) |
| reg_val | input | 8 | Value of the register named by the opcode |
| flags | input | 4 | Flag register: bit 0 carry, 1 overflow, 2 interrupt enable, 3 user |
| seq_ip | input | 12 | Address of the next sequential instruction |
| res_valid | output | 1 | One-cycle pulse marking a resolved address |
| next_ip | output | 12 | Resolved next instruction address |
| taken | output | 1 | High when control was redirected |

## Verification
The assertions take for granted that reset is applied before the first request and that the captured operands stand for a single instruction, so the checked output can be compared against the operand registers of the request that produced it. They also assume a caller never expects a second result from a request raised while busy. The stimulus drives every request on the falling edge, holds `req_valid` for one cycle except in the scenario that deliberately keeps it high through the busy states, and samples results on the falling edge after the done state is entered.

// File: rtl/fru_pkg.sv
package fru_pkg;

    typedef enum logic [2:0] {
        BK_NONE,
        BK_JUMP,
        BK_JUMP_OFS,
        BK_SKIP,
        BK_COND
    } branch_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_DONE
    } fru_state_e;

    typedef struct packed {
        branch_kind_e kind;
        logic         backward;
        logic [1:0]   flag_sel;
        logic         want_set;
    } branch_decode_t;

endpackage

// File: rtl/fru_decode.sv
module fru_decode
    import fru_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0] opcode,
    output branch_decode_t  dec
);

    localparam int GRP_LSB = OP_W - 5;

    logic [4:0] group;

    assign group = opcode[OP_W-1:GRP_LSB];

    always_comb begin
        dec          = '0;
        dec.kind     = BK_NONE;
        dec.flag_sel = opcode[1:0];
        dec.want_set = opcode[2];
        unique casez (group)
            5'b11000: dec.kind = BK_JUMP;
            5'b11001: dec.kind = BK_JUMP_OFS;
            5'b1110?: begin
                dec.kind     = BK_SKIP;
                dec.backward = group[0];
            end
            5'b1111?: begin
                dec.kind     = BK_COND;
                dec.backward = group[0];
            end
            default:  dec.kind = BK_NONE;
        endcase
    end

endmodule

// File: rtl/fru_cond.sv
module fru_cond #(
    parameter int FLAG_W = 4,
    localparam int SEL_W = $clog2(FLAG_W)
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic [SEL_W-1:0]  flag_sel,
    input  logic              want_set,
    output logic              cond_ok
);

    logic [FLAG_W-1:0] match_vec;

    genvar g;
    generate
        for (g = 0; g < FLAG_W; g++) begin : g_match
            assign match_vec[g] = ~(flags[g] ^ want_set);
        end
    endgenerate

    assign cond_ok = match_vec[flag_sel];

endmodule

// File: rtl/fru_target.sv
module fru_target
    import fru_pkg::*;
#(
    parameter int IP_W   = 12,
    parameter int DATA_W = 8,
    localparam int HI_W  = IP_W - DATA_W
) (
    input  branch_kind_e      kind,
    input  logic              backward,
    input  logic              cond_ok,
    input  logic [DATA_W-1:0] imm_a,
    input  logic [DATA_W-1:0] imm_b,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [IP_W-1:0]   seq_ip,
    output logic [IP_W-1:0]   target,
    output logic              redirect
);

    logic [IP_W-1:0] abs_addr;
    logic [IP_W-1:0] disp_ext;
    logic [IP_W-1:0] reg_ext;
    logic [IP_W-1:0] rel_addr;

    assign abs_addr = {imm_a[HI_W-1:0], imm_b};
    assign disp_ext = {{HI_W{1'b0}}, imm_a};
    assign reg_ext  = {{HI_W{1'b0}}, reg_val};
    assign rel_addr = backward ? (seq_ip - disp_ext) : (seq_ip + disp_ext);

    always_comb begin
        target   = seq_ip;
        redirect = 1'b0;
        unique case (kind)
            BK_JUMP: begin
                target   = abs_addr;
                redirect = 1'b1;
            end
            BK_JUMP_OFS: begin
                target   = abs_addr + reg_ext;
                redirect = 1'b1;
            end
            BK_SKIP: begin
                target   = rel_addr;
                redirect = 1'b1;
            end
            BK_COND: begin
                if (cond_ok) begin
                    target   = rel_addr;
                    redirect = 1'b1;
                end
            end
            default: begin
                target   = seq_ip;
                redirect = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/flow_redirect_unit.sv
module flow_redirect_unit
    import fru_pkg::*;
#(
    parameter int IP_W   = 12,
    parameter int DATA_W = 8,
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] opcode,
    input  logic [DATA_W-1:0] imm_a,
    input  logic [DATA_W-1:0] imm_b,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [FLAG_W-1:0] flags,
    input  logic [IP_W-1:0]   seq_ip,
    output logic              res_valid,
    output logic [IP_W-1:0]   next_ip,
    output logic              taken
);

    localparam int HI_W = IP_W - DATA_W;

    fru_state_e state_q, state_d;

    logic [DATA_W-1:0] op_q, imm_a_q, imm_b_q, reg_q;
    logic [FLAG_W-1:0] flags_q;
    logic [IP_W-1:0]   seq_q;

    branch_decode_t    dec;
    logic              cond_ok;
    logic [IP_W-1:0]   target;
    logic              redirect;

    logic [IP_W-1:0]   next_ip_q;
    logic              taken_q;

    logic              accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_CALC;
            ST_CALC: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            imm_a_q <= '0;
            imm_b_q <= '0;
            reg_q   <= '0;
            flags_q <= '0;
            seq_q   <= '0;
        end else if (accept) begin
            op_q    <= opcode;
            imm_a_q <= imm_a;
            imm_b_q <= imm_b;
            reg_q   <= reg_val;
            flags_q <= flags;
            seq_q   <= seq_ip;
        end
    end

    fru_decode #(.OP_W(DATA_W)) u_decode (
        .opcode (op_q),
        .dec    (dec)
    );

    fru_cond #(.FLAG_W(FLAG_W)) u_cond (
        .flags    (flags_q),
        .flag_sel (dec.flag_sel[$clog2(FLAG_W)-1:0]),
        .want_set (dec.want_set),
        .cond_ok  (cond_ok)
    );

    fru_target #(.IP_W(IP_W), .DATA_W(DATA_W)) u_target (
        .kind     (dec.kind),
        .backward (dec.backward),
        .cond_ok  (cond_ok),
        .imm_a    (imm_a_q),
        .imm_b    (imm_b_q),
        .reg_val  (reg_q),
        .seq_ip   (seq_q),
        .target   (target),
        .redirect (redirect)
    );

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_ip_q <= '0;
            taken_q   <= 1'b0;
        end else if (state_q == ST_CALC) begin
            next_ip_q <= target;
            taken_q   <= redirect;
        end
    end

    assign res_valid = (state_q == ST_DONE);
    assign next_ip   = next_ip_q;
    assign taken     = taken_q;

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid) |=> ##1 res_valid);

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_abs_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && op_q[7:3] == 5'b11000) |->
        (taken && next_ip == {imm_a_q[HI_W-1:0], imm_b_q}));

    assert_skip_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && op_q[7:3] == 5'b11101) |->
        (taken && next_ip == seq_q - {{HI_W{1'b0}}, imm_a_q}));

    assert_untaken_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !taken) |-> (next_ip == seq_q));

    assert_other_untaken_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && op_q[7:6] != 2'b11) |-> !taken);

    assert_capture_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(op_q) && $stable(seq_q));

endmodule

// File: tb/flow_redirect_unit_tb_top.sv
`timescale 1ns/1ps
module flow_redirect_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  imm_a = '0;
    logic [7:0]  imm_b = '0;
    logic [7:0]  reg_val = '0;
    logic [3:0]  flags = '0;
    logic [11:0] seq_ip = '0;
    logic        res_valid;
    logic [11:0] next_ip;
    logic        taken;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    flow_redirect_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .opcode    (opcode),
        .imm_a     (imm_a),
        .imm_b     (imm_b),
        .reg_val   (reg_val),
        .flags     (flags),
        .seq_ip    (seq_ip),
        .res_valid (res_valid),
        .next_ip   (next_ip),
        .taken     (taken)
    );

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [7:0] op, logic [7:0] a, logic [7:0] b,
                         logic [7:0] r, logic [3:0] f, logic [11:0] s);
        @(negedge clk);
        opcode = op; imm_a = a; imm_b = b; reg_val = r; flags = f; seq_ip = s;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_result(string tag, logic [11:0] ip, logic tk);
        chk({tag, " valid"}, int'(res_valid), 1);
        chk({tag, " next_ip"}, int'(next_ip), int'(ip));
        chk({tag, " taken"}, int'(taken), int'(tk));
    endtask

    task automatic t_reset_r1();
        chk("R1 res_valid", int'(res_valid), 0);
        chk("R1 next_ip", int'(next_ip), 0);
        chk("R1 taken", int'(taken), 0);
    endtask

    task automatic t_latency_r2();
        @(negedge clk);
        opcode = 8'hC0; imm_a = 8'h01; imm_b = 8'h23; seq_ip = 12'h010;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 not early", int'(res_valid), 0);
        @(negedge clk);
        chk("R2 valid at two edges", int'(res_valid), 1);
        @(negedge clk);
        chk("R2 one-cycle pulse", int'(res_valid), 0);
    endtask

    task automatic t_jump_r3();
        issue(8'hC5, 8'hF7, 8'hA9, 8'h00, 4'h0, 12'h100);
        expect_result("R3 jump hi nibble only", 12'h7A9, 1'b1);
    endtask

    task automatic t_jump_ofs_r4();
        issue(8'hCB, 8'h02, 8'h10, 8'h35, 4'h0, 12'h040);
        expect_result("R4 jump offset", 12'h245, 1'b1);
        issue(8'hC9, 8'h0F, 8'hF0, 8'h20, 4'h0, 12'h040);
        expect_result("R4 R10 offset wrap", 12'h010, 1'b1);
    endtask

    task automatic t_skip_r5();
        issue(8'hE0, 8'h30, 8'h00, 8'h00, 4'h0, 12'h200);
        expect_result("R5 skip fwd", 12'h230, 1'b1);
        issue(8'hE8, 8'h10, 8'h00, 8'h00, 4'h0, 12'h200);
        expect_result("R5 skip back", 12'h1F0, 1'b1);
        issue(8'hE8, 8'h02, 8'h00, 8'h00, 4'hF, 12'h016);
        expect_result("R5 R7 rewind 2 self", 12'h014, 1'b1);
    endtask

    task automatic t_cond_r6_r7_r8();
        for (int op = 0; op < 16; op++) begin
            for (int f = 0; f < 16; f++) begin
                logic [3:0] ff;
                logic       want, hit, bk;
                logic [11:0] exp_ip;
                ff   = 4'(f);
                want = op[2];
                bk   = op[3];
                hit  = (ff[op[1:0]] == want);
                exp_ip = !hit ? 12'h300 : (bk ? 12'h300 - 12'h005 : 12'h300 + 12'h005);
                issue(8'hF0 | 8'(op), 8'h05, 8'h00, 8'h00, ff, 12'h300);
                if (hit) expect_result("R6 R7 cond taken", exp_ip, 1'b1);
                else     expect_result("R6 R8 cond not taken", exp_ip, 1'b0);
            end
        end
    endtask

    task automatic t_other_r9();
        logic [7:0] ops [6] = '{8'h00, 8'h47, 8'h7F, 8'h90, 8'hD0, 8'hD8};
        for (int i = 0; i < 6; i++) begin
            issue(ops[i], 8'h44, 8'h55, 8'h66, 4'hF, 12'h123);
            expect_result("R9 other opcode", 12'h123, 1'b0);
        end
    endtask

    task automatic t_wrap_r10();
        issue(8'hE0, 8'hFF, 8'h00, 8'h00, 4'h0, 12'hF80);
        expect_result("R10 fwd wrap", 12'h07F, 1'b1);
        issue(8'hFC, 8'h10, 8'h00, 8'h00, 4'h1, 12'h008);
        expect_result("R10 back wrap", 12'hFF8, 1'b1);
    endtask

    task automatic t_busy_r11();
        @(negedge clk);
        opcode = 8'hE0; imm_a = 8'h04; flags = 4'h0; seq_ip = 12'h500;
        req_valid = 1'b1;
        @(negedge clk);
        opcode = 8'hC0; imm_a = 8'h0A; imm_b = 8'hBC; seq_ip = 12'h777;
        @(negedge clk);
        expect_result("R11 busy request ignored", 12'h504, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 no result from busy request", int'(res_valid), 0);
        @(negedge clk);
        @(negedge clk);
        chk("R11 stays idle", int'(res_valid), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #1;
        t_reset_r1();
        repeat (3) @(negedge clk);
        t_reset_r1();
        rst_n = 1'b1;
        t_latency_r2();
        t_jump_r3();
        t_jump_ofs_r4();
        t_skip_r5();
        t_cond_r6_r7_r8();
        t_other_r9();
        t_wrap_r10();
        t_busy_r11();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end

endmodule